// File: doc/BRIEF.md
# Stop/Wait Wake-Up Clock Stabilization Controller

This block brings a small microcontroller core back from its two low-power states. A stop request drops the oscillator and PLL enables together with every clock enable. A wake-up interrupt then turns the oscillator and PLL enables back on. After that, the block keeps the CPU and bus-interface clock enables low until the clock can be trusted. In counting mode, a stabilization down-counter is reloaded to all ones and steps down on a selectable divided oscillator tick. The enables return once its top bit reads zero. In direct mode, the counter is bypassed and the enables return at the first falling level of the selected divided tick.

A wait request gates only the CPU and bus clocks. A configuration bit decides whether the system clock also stops while waiting. Two status flags record that a stop or a wait is in progress. A warm reset does not change them, and only a power-on reset clears them. A free-running prescaler, held at zero while stopped, produces the divided ticks. It also drives a watchdog tick with two rates and the count enable for an event timer, which counts either a pin's edges or a divided tick.

Top module: `wake_stab_ctrl`

## Requirements
- R1: After power-on reset (rst_ni low) the oscillator, PLL, CPU, bus and system clock enables are 1, both status flags are 0 and the config register is all zeros.
- R2: A stop_req_i pulse while running makes all five enables 0 and sets stop_flag_o in the next cycle.
- R3: Config bits [4:3] choose the stabilization tick: 00 divide-by-32, 01 divide-by-16, 10 divide-by-128, 11 divide-by-64. In counting mode, the CPU and bus enables return exactly 2^(CNT_W-1)*N+1 clock edges after the edge that samples wake_irq_i. The oscillator and PLL enables are back on from that edge.
- R4: Counting mode applies when ext_clk_i is 0 or sys_clk_sel_i is 1.
- R5: With ext_clk_i=1 and sys_clk_sel_i=0, the CPU and bus enables return N+1 edges after the wake edge, at the first falling level of the selected tick.
- R6: A stop request while stopped, recovering or waiting has no effect. The recovery latency stays unchanged.
- R7: stop_flag_o and wait_flag_o keep their value through warm_rst_i, which returns the controller to running. A power-on reset clears them.
- R8: Config writes, even of all ones, never change either status flag.
- R9: A wait_req_i pulse while running drops the CPU and bus enables, keeps the oscillator enable and sets wait_flag_o. The system enable stays at the inverse of config bit 0. The next wake_irq_i returns to running one edge later.
- R10: wdt_tick_o pulses once every 512 cycles when config bit 2 is 0 and once every 32 cycles when it is 1.
- R11: tmr_evt_o is a registered pulse. It follows the divide-by-32 tick when config bit 1 is 1, and each rising edge of tmr_pin_i when it is 0.
- R12: A completed wake from stop clears stop_flag_o, and a completed wake from wait clears wait_flag_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| warm_rst_i | input | 1 | Hardware/software reset, synchronous |
| stop_req_i | input | 1 | Stop instruction executing |
| wait_req_i | input | 1 | Wait instruction executing |
| wake_irq_i | input | 1 | Wake-up interrupt |
| ext_clk_i | input | 1 | External clock input mode |
| sys_clk_sel_i | input | 1 | System clock source select |
| wr_en_i | input | 1 | Config register write strobe |
| wr_data_i | input | 5 | Config write data |
| tmr_pin_i | input | 1 | Timer event pin |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| biu_clk_en_o | output | 1 | Bus-interface clock enable |
| sys_clk_en_o | output | 1 | System clock enable |
| stop_flag_o | output | 1 | Stop in progress status |
| wait_flag_o | output | 1 | Wait in progress status |
| wdt_tick_o | output | 1 | Watchdog prescale tick |
| tmr_evt_o | output | 1 | Event timer count enable |

## Verification
The assertions check on every cycle that the CPU clock never runs without the oscillator, and that the system clock never runs gated while the CPU clock is on. They also check that the stop flag is set whenever the oscillator is off, that it cannot rise without a stop request, that a warm reset leaves both flags unchanged, and that a stop request during recovery leaves the oscillator on. Only the bench scenarios can show the exact recovery latencies for each tick choice and each clock mode, the wait-mode gating, and the watchdog and timer pulse rates. The bench sweeps all four tick selections across all four mode combinations, with a small counter width.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int PRE_W  = 9;
  localparam int TAP_W  = $clog2(PRE_W);
  localparam int CFG_W  = 5;
  localparam int TAP16  = 3;
  localparam int TAP32  = 4;
  localparam int TAP64  = 5;
  localparam int TAP128 = 6;
  localparam int TAP512 = 8;

  typedef enum logic [2:0] {
    ST_RUN, ST_STOP, ST_STAB, ST_EDGE, ST_WAIT
  } wake_state_e;

  typedef struct packed {
    logic [1:0] stab_sel;
    logic       wdt_fast;
    logic       tmr_src;
    logic       wclk_stop;
  } wake_cfg_t;

  function automatic logic [TAP_W-1:0] sel_to_tap(input logic [1:0] sel);
    case (sel)
      2'b00:   return TAP_W'(TAP32);
      2'b01:   return TAP_W'(TAP16);
      2'b10:   return TAP_W'(TAP128);
      default: return TAP_W'(TAP64);
    endcase
  endfunction
endpackage

// File: rtl/wake_prescaler.sv
module wake_prescaler
  import wake_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  output logic [PRE_W-1:0] tick_o,
  output logic [PRE_W-1:0] lvl_o
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (hold_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // tap i divides by 2^(i+1)
  for (genvar i = 0; i < PRE_W; i++) begin : g_tap
    assign tick_o[i] = &cnt_q[i:0];
    assign lvl_o[i]  = cnt_q[i];
  end
endmodule

// File: rtl/wake_stab_counter.sv
module wake_stab_counter #(
  parameter int CNT_W = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '1;
    else if (load_i) cnt_q <= '1;
    else if (dec_i && cnt_q[CNT_W-1]) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = ~cnt_q[CNT_W-1];
endmodule

// File: rtl/wake_cfg_regs.sv
module wake_cfg_regs
  import wake_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             warm_rst_i,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic             set_stop_i,
  input  logic             clr_stop_i,
  input  logic             set_wait_i,
  input  logic             clr_wait_i,
  output wake_cfg_t        cfg_o,
  output logic             stop_flag_o,
  output logic             wait_flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cfg_o <= '0;
    else if (warm_rst_i) cfg_o <= '0;
    else if (wr_en_i)    cfg_o <= wake_cfg_t'(wr_data_i);
  end

  // status flags: power-on reset only, no write path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_flag_o <= 1'b0;
      wait_flag_o <= 1'b0;
    end else if (!warm_rst_i) begin
      if (set_stop_i)      stop_flag_o <= 1'b1;
      else if (clr_stop_i) stop_flag_o <= 1'b0;
      if (set_wait_i)      wait_flag_o <= 1'b1;
      else if (clr_wait_i) wait_flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wake_stab_ctrl.sv
module wake_stab_ctrl
  import wake_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             warm_rst_i,
  input  logic             stop_req_i,
  input  logic             wait_req_i,
  input  logic             wake_irq_i,
  input  logic             ext_clk_i,
  input  logic             sys_clk_sel_i,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic             tmr_pin_i,
  output logic             osc_en_o,
  output logic             pll_en_o,
  output logic             cpu_clk_en_o,
  output logic             biu_clk_en_o,
  output logic             sys_clk_en_o,
  output logic             stop_flag_o,
  output logic             wait_flag_o,
  output logic             wdt_tick_o,
  output logic             tmr_evt_o
);
  wake_state_e      state_q, state_d;
  wake_cfg_t        cfg;
  logic [PRE_W-1:0] tick, lvl;
  logic [TAP_W-1:0] tap;
  logic             tick_sel, lvl_sel, lvl_q, fall, cnt_done, count_mode;
  logic             pin_q, evt_q;

  wake_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (state_q == ST_STOP),
    .tick_o (tick),
    .lvl_o  (lvl)
  );

  assign tap      = sel_to_tap(cfg.stab_sel);
  assign tick_sel = tick[tap];
  assign lvl_sel  = lvl[tap];
  assign fall     = lvl_q & ~lvl_sel;

  wake_stab_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q != ST_STAB),
    .dec_i  (tick_sel),
    .done_o (cnt_done)
  );

  assign count_mode = ~ext_clk_i | sys_clk_sel_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (stop_req_i) state_d = ST_STOP;
               else if (wait_req_i) state_d = ST_WAIT;
      ST_STOP: if (wake_irq_i) state_d = count_mode ? ST_STAB : ST_EDGE;
      ST_STAB: if (cnt_done) state_d = ST_RUN;
      ST_EDGE: if (fall) state_d = ST_RUN;
      ST_WAIT: if (wake_irq_i) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      lvl_q   <= 1'b0;
    end else begin
      state_q <= warm_rst_i ? ST_RUN : state_d;
      lvl_q   <= lvl_sel;
    end
  end

  wake_cfg_regs u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .warm_rst_i  (warm_rst_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .set_stop_i  (state_q == ST_RUN && state_d == ST_STOP),
    .clr_stop_i  ((state_q == ST_STAB || state_q == ST_EDGE) && state_d == ST_RUN),
    .set_wait_i  (state_q == ST_RUN && state_d == ST_WAIT),
    .clr_wait_i  (state_q == ST_WAIT && state_d == ST_RUN),
    .cfg_o       (cfg),
    .stop_flag_o (stop_flag_o),
    .wait_flag_o (wait_flag_o)
  );

  // timer count enable, registered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      pin_q <= tmr_pin_i;
      evt_q <= cfg.tmr_src ? tick[TAP32] : (tmr_pin_i & ~pin_q);
    end
  end

  assign osc_en_o     = state_q != ST_STOP;
  assign pll_en_o     = state_q != ST_STOP;
  assign cpu_clk_en_o = state_q == ST_RUN;
  assign biu_clk_en_o = state_q == ST_RUN;
  assign sys_clk_en_o = (state_q == ST_RUN) || (state_q == ST_WAIT && !cfg.wclk_stop);
  assign wdt_tick_o   = cfg.wdt_fast ? tick[TAP32] : tick[TAP512];
  assign tmr_evt_o    = evt_q;
endmodule

// File: rtl/wake_stab_chk.sv
module wake_stab_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic warm_rst_i,
  input logic stop_req_i,
  input logic osc_en_o,
  input logic cpu_clk_en_o,
  input logic sys_clk_en_o,
  input logic stop_flag_o,
  input logic wait_flag_o
);
  assert_cpu_needs_osc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o |-> osc_en_o);

  assert_osc_off_flagged_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> stop_flag_o);

  assert_flag_no_spurious_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_flag_o && !stop_req_i) |=> !stop_flag_o);

  assert_warm_keeps_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_i |=> $stable(stop_flag_o));

  assert_warm_keeps_wait_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_i |=> $stable(wait_flag_o));

  assert_stop_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_req_i && osc_en_o && !cpu_clk_en_o) |=> osc_en_o);

  assert_sys_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_clk_en_o |-> !cpu_clk_en_o);
endmodule

bind wake_stab_ctrl wake_stab_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .warm_rst_i   (warm_rst_i),
  .stop_req_i   (stop_req_i),
  .osc_en_o     (osc_en_o),
  .cpu_clk_en_o (cpu_clk_en_o),
  .sys_clk_en_o (sys_clk_en_o),
  .stop_flag_o  (stop_flag_o),
  .wait_flag_o  (wait_flag_o)
);

// File: tb/tb_wake_stab_ctrl.sv
module tb_wake_stab_ctrl;
  localparam int CNT_W = 4;
  localparam int D     = 1 << (CNT_W - 1);

  logic clk = 1'b0, rst_n = 1'b0, warm = 1'b0, stop_req = 1'b0, wait_req = 1'b0;
  logic wake = 1'b0, ext_clk = 1'b0, sys_sel = 1'b0, wr_en = 1'b0, pin = 1'b0;
  logic [4:0] wr_data = '0;
  logic osc_en, pll_en, cpu_en, biu_en, sys_en, stop_flag, wait_flag, wdt_tick, tmr_evt;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  wake_stab_ctrl #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .warm_rst_i(warm), .stop_req_i(stop_req),
    .wait_req_i(wait_req), .wake_irq_i(wake), .ext_clk_i(ext_clk),
    .sys_clk_sel_i(sys_sel), .wr_en_i(wr_en), .wr_data_i(wr_data), .tmr_pin_i(pin),
    .osc_en_o(osc_en), .pll_en_o(pll_en), .cpu_clk_en_o(cpu_en), .biu_clk_en_o(biu_en),
    .sys_clk_en_o(sys_en), .stop_flag_o(stop_flag), .wait_flag_o(wait_flag),
    .wdt_tick_o(wdt_tick), .tmr_evt_o(tmr_evt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [4:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
  endtask

  // returns edges from wake-sampling edge until cpu enable observed
  task automatic wake_lat(input int inject_at, output int lat);
    @(negedge clk); wake = 1'b1;
    lat = 0;
    forever begin
      @(negedge clk);
      wake = 1'b0;
      stop_req = (lat == inject_at);
      if (cpu_en || lat > 5000) break;
      lat++;
    end
    stop_req = 1'b0;
  endtask

  function automatic int div_of(input int sel);
    case (sel)
      0: return 32;
      1: return 16;
      2: return 128;
      default: return 64;
    endcase
  endfunction

  task automatic count_pulses(input int cycles, output int wd, output int ev);
    wd = 0; ev = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      wd += int'(wdt_tick);
      ev += int'(tmr_evt);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lat, wd, ev, n;
    logic cm;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 enables", {osc_en, pll_en, cpu_en, biu_en, sys_en}, 5'b11111);
    chk("R1 flags", {stop_flag, wait_flag}, 0);

    // sweep modes x tick selections
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        ext_clk = m[1]; sys_sel = m[0];
        cm = !ext_clk || sys_sel;
        n = div_of(s);
        cfg_wr(5'(s << 3));
        pulse_stop();
        chk("R2 enables off", {osc_en, pll_en, cpu_en, biu_en, sys_en}, 0);
        chk("R2 stop flag", stop_flag, 1);
        repeat (4) @(negedge clk);
        wake_lat(-1, lat);
        if (cm) chk("R3 R4 counting latency", lat, D * n + 1);
        else    chk("R5 edge latency", lat, n + 1);
        chk("R12 stop flag cleared", stop_flag, 0);
      end
    end

    // R6: stop during recovery
    ext_clk = 1'b0; sys_sel = 1'b0;
    cfg_wr(5'b01000);
    pulse_stop();
    pulse_stop();
    chk("R6 stop while stopped", osc_en, 0);
    repeat (3) @(negedge clk);
    wake_lat(10, lat);
    chk("R6 latency unchanged", lat, D * 16 + 1);

    // R7/R8: warm reset retention and write immunity
    pulse_stop();
    @(negedge clk); warm = 1'b1;
    @(negedge clk); warm = 1'b0;
    chk("R7 warm returns to run", cpu_en, 1);
    chk("R7 stop flag kept", stop_flag, 1);
    cfg_wr(5'b00000);
    chk("R8 write leaves flag set", stop_flag, 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R7 por clears flag", stop_flag, 0);
    cfg_wr(5'b11111);
    chk("R8 write leaves flags clear", {stop_flag, wait_flag}, 0);

    // R9: wait with and without system clock gate
    for (int g = 0; g < 2; g++) begin
      cfg_wr(5'(g));
      @(negedge clk); wait_req = 1'b1;
      @(negedge clk); wait_req = 1'b0;
      chk("R9 cpu off in wait", {cpu_en, biu_en}, 0);
      chk("R9 osc on in wait", osc_en, 1);
      chk("R9 sys per gate bit", sys_en, 1 - g);
      chk("R9 wait flag", wait_flag, 1);
      @(negedge clk); stop_req = 1'b1;
      @(negedge clk); stop_req = 1'b0;
      chk("R6 stop ignored in wait", osc_en, 1);
      @(negedge clk); wake = 1'b1;
      @(negedge clk); wake = 1'b0;
      chk("R9 wake from wait", cpu_en, 1);
      chk("R12 wait flag cleared", wait_flag, 0);
    end

    // R10/R11: prescaled outputs
    cfg_wr(5'b00000);
    count_pulses(1024, wd, ev);
    chk("R10 slow watchdog rate", wd, 2);
    cfg_wr(5'b00110);
    count_pulses(1024, wd, ev);
    chk("R10 fast watchdog rate", wd, 32);
    chk("R11 timer div32 events", ev, 32);
    cfg_wr(5'b00000);
    repeat (2) @(negedge clk);
    ev = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      ev += int'(tmr_evt);
      pin = ~pin;
    end
    repeat (2) begin @(negedge clk); ev += int'(tmr_evt); end
    chk("R11 pin rising edges", ev, 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule